// File: doc/BRIEF.md
# Five-State Snooping Line Coherence Controller

This block keeps the coherence state of a single cache line on a snooping bus. It uses the five states Invalid, Shared, Exclusive, Owned and Modified. The Owned state lets a dirty line be shared with other caches without first being written back to memory. Whenever the line is in Modified or Owned, this cache answers snooped reads itself. In that case it raises a supply flag so that memory stays silent, and the requester gets the data cache-to-cache. When a snooped read finds the line Modified, the line moves to Owned and no write-back is made.

On the local side the block takes read, write and eviction requests. It answers with the bus transaction it needs (read, read-for-ownership or upgrade), and it raises a write-back request when a dirty line is evicted. The bus is treated as atomic. A local bus request is decided in the same cycle it is issued, and the combined shared response of the other caches (`shared_in`) is sampled in that same cycle. Data storage, tags and the memory controller live outside the block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `state_q` is Invalid and every output is low. State codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Owned and 4 Modified.
- R2: A local read in Invalid issues a bus read (`bus_req_kind` 0). The line then moves to Shared if `shared_in` is high, and to Exclusive if it is low. A local read in any valid state issues no bus request and leaves the state unchanged.
- R3: A local write always ends in Modified. From Invalid it issues a read-for-ownership (kind 1). From Shared or Owned it issues an upgrade (kind 2). From Exclusive or Modified it issues no bus request.
- R4: A snooped bus read (`snp_kind` 0) in Modified raises `shared_out` and `supply_out` and moves the line to Owned. No write-back is requested.
- R5: A snooped bus read in Owned raises `shared_out` and `supply_out` and the line stays Owned. In Exclusive it raises only `shared_out` and the line moves to Shared. In Shared it raises only `shared_out` and the line stays Shared. In Invalid it has no effect.
- R6: A snooped read-for-ownership (`snp_kind` 1) raises `supply_out` in Modified or Owned, and in no other state. From any state the line ends Invalid.
- R7: A snooped upgrade (`snp_kind` 2) moves any state to Invalid and never raises `supply_out`.
- R8: Evicting a line in Modified or Owned raises `wb_req` and moves it to Invalid. Evicting a line in Exclusive or Shared moves it to Invalid silently. Evicting in Invalid has no effect.
- R9: Only one event is acted on per cycle, in the priority order snoop, eviction, write, read. Any lower-priority request in that cycle is dropped: it issues no bus request and has no effect on the state.
- R10: In a cycle with no request, every output is low and the state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_rd | input | 1 | Local read request |
| loc_wr | input | 1 | Local write request |
| evict | input | 1 | Local eviction of the line |
| shared_in | input | 1 | Wired-OR shared response from other caches to this cycle's bus request |
| snp_valid | input | 1 | A snooped transaction for this line is present |
| snp_kind | input | 2 | Snooped kind: 0 read, 1 read-for-ownership, 2 upgrade |
| bus_req_valid | output | 1 | This cache issues a bus transaction |
| bus_req_kind | output | 2 | Kind of issued transaction, same codes as `snp_kind` |
| shared_out | output | 1 | This cache holds a copy of a snooped line |
| supply_out | output | 1 | This cache drives the data; memory must not respond |
| wb_req | output | 1 | Write the dirty line back to memory |
| state_q | output | 3 | Current line state |

## Verification
The assertions assume `snp_kind` never carries the reserved code 3 while `snp_valid` is high. They also assume that an upgrade is only snooped from another cache that holds a copy. The state checks themselves hold for any legal sequence. The stimulus draws the snoop kind only from the three defined codes. It mixes colliding local and snooped requests in the same cycle, so that the priority order is exercised under every state the random walk reaches.

// File: rtl/moesi_pkg.sv
// Shared types for the line coherence controller.
package moesi_pkg;
    localparam int ST_W = 3;
    localparam int TX_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [TX_W-1:0] {
        TX_RD  = 2'd0,
        TX_RDX = 2'd1,
        TX_UPG = 2'd2,
        TX_RSV = 2'd3
    } bus_tx_e;

    typedef struct packed {
        logic     req_vld;
        bus_tx_e  req_kind;
        logic     wb;
        line_st_e nxt;
    } local_act_t;

    typedef struct packed {
        logic     shared;
        logic     supply;
        line_st_e nxt;
    } snoop_act_t;
endpackage

// File: rtl/moesi_snoop_resp.sv
// Snoop responder: decides the reply and the next state for one snooped
// transaction. Assumes the reserved kind is never presented; it holds state.
module moesi_snoop_resp
    import moesi_pkg::*;
(
    input  line_st_e   cur,
    input  bus_tx_e    kind,
    output snoop_act_t act
);
    logic dirty;
    assign dirty = (cur == ST_M) || (cur == ST_O);

    // Reply and next state for the snooped kind.
    always_comb begin
        act = '{shared: 1'b0, supply: 1'b0, nxt: cur};
        unique case (kind)
            TX_RD: begin
                if (cur != ST_I) act.shared = 1'b1;
                act.supply = dirty;
                if (cur == ST_M)      act.nxt = ST_O;
                else if (cur == ST_E) act.nxt = ST_S;
            end
            TX_RDX: begin
                act.supply = dirty;
                act.nxt    = ST_I;
            end
            TX_UPG: act.nxt = ST_I;
            default: act.nxt = cur;
        endcase
    end
endmodule

// File: rtl/moesi_local_req.sv
// Local request decoder: picks one of eviction, write or read, in that priority
// order, and decides the bus request, write-back and next state. Assumes the
// bus is atomic, so shared_in answers this cycle's read.
module moesi_local_req
    import moesi_pkg::*;
(
    input  line_st_e   cur,
    input  logic       rd,
    input  logic       wr,
    input  logic       ev,
    input  logic       shared_in,
    output local_act_t act
);
    // Prioritised decision for the local side.
    always_comb begin
        act = '{req_vld: 1'b0, req_kind: TX_RD, wb: 1'b0, nxt: cur};
        if (ev) begin
            act.wb  = (cur == ST_M) || (cur == ST_O);
            act.nxt = ST_I;
        end else if (wr) begin
            act.nxt = ST_M;
            unique case (cur)
                ST_I: begin
                    act.req_vld  = 1'b1;
                    act.req_kind = TX_RDX;
                end
                ST_S, ST_O: begin
                    act.req_vld  = 1'b1;
                    act.req_kind = TX_UPG;
                end
                default: act.req_vld = 1'b0;
            endcase
        end else if (rd && cur == ST_I) begin
            act.req_vld  = 1'b1;
            act.req_kind = TX_RD;
            act.nxt      = shared_in ? ST_S : ST_E;
        end
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
// Per-line five-state coherence controller. A snoop outranks every local
// request; the state register is the only storage. Outputs are combinational
// from the state and this cycle's requests.
module moesi_line_ctrl
    import moesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loc_rd,
    input  logic       loc_wr,
    input  logic       evict,
    input  logic       shared_in,
    input  logic       snp_valid,
    input  logic [1:0] snp_kind,
    output logic       bus_req_valid,
    output logic [1:0] bus_req_kind,
    output logic       shared_out,
    output logic       supply_out,
    output logic       wb_req,
    output logic [2:0] state_q
);
    line_st_e   st_r;
    line_st_e   st_nxt;
    snoop_act_t s_act;
    local_act_t l_act;

    moesi_snoop_resp u_snoop (
        .cur  (st_r),
        .kind (bus_tx_e'(snp_kind)),
        .act  (s_act)
    );

    moesi_local_req u_local (
        .cur       (st_r),
        .rd        (loc_rd),
        .wr        (loc_wr),
        .ev        (evict),
        .shared_in (shared_in),
        .act       (l_act)
    );

    // Arbitration: a snoop suppresses the whole local side.
    always_comb begin
        st_nxt        = snp_valid ? s_act.nxt : l_act.nxt;
        bus_req_valid = !snp_valid && l_act.req_vld;
        bus_req_kind  = bus_req_valid ? l_act.req_kind : TX_RD;
        wb_req        = !snp_valid && l_act.wb;
        shared_out    = snp_valid && s_act.shared;
        supply_out    = snp_valid && s_act.supply;
    end

    // Line state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= ST_I;
        else        st_r <= st_nxt;
    end

    assign state_q = st_r;
endmodule

// File: rtl/moesi_line_chk.sv
// Checker for the line controller: temporal properties on its ports.
module moesi_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loc_rd,
    input logic       loc_wr,
    input logic       evict,
    input logic       snp_valid,
    input logic [1:0] snp_kind,
    input logic       bus_req_valid,
    input logic       supply_out,
    input logic       wb_req,
    input logic [2:0] state_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> state_q == 3'd0); // R1
    AST_WR_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr && !evict && !snp_valid |=> state_q == 3'd4); // R3
    AST_RD_M_TO_O: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_kind == 2'd0 && state_q == 3'd4 |=> state_q == 3'd3); // R4
    AST_SUPPLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        supply_out |-> state_q == 3'd3 || state_q == 3'd4); // R6
    AST_UPG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_kind == 2'd2 |=> state_q == 3'd0); // R7
    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> evict && (state_q == 3'd3 || state_q == 3'd4)); // R8
    AST_WB_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> state_q == 3'd0); // R8
    AST_SNOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !bus_req_valid && !wb_req); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid && !loc_rd && !loc_wr && !evict |=> $stable(state_q)); // R10
endmodule

bind moesi_line_ctrl moesi_line_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_rd        (loc_rd),
    .loc_wr        (loc_wr),
    .evict         (evict),
    .snp_valid     (snp_valid),
    .snp_kind      (snp_kind),
    .bus_req_valid (bus_req_valid),
    .supply_out    (supply_out),
    .wb_req        (wb_req),
    .state_q       (state_q)
);

// File: tb/moesi_line_ctrl_tb.sv
module moesi_line_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_rd = 1'b0, loc_wr = 1'b0, evict = 1'b0, shared_in = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_kind = 2'd0;
    logic       bus_req_valid, shared_out, supply_out, wb_req;
    logic [1:0] bus_req_kind;
    logic [2:0] state_q;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [2:0]  exp_st = 3'd0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    moesi_line_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .loc_rd(loc_rd), .loc_wr(loc_wr),
        .evict(evict), .shared_in(shared_in), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .bus_req_valid(bus_req_valid),
        .bus_req_kind(bus_req_kind), .shared_out(shared_out),
        .supply_out(supply_out), .wb_req(wb_req), .state_q(state_q)
    );

    // Expected {nxt[2:0], bus_valid, bus_kind[1:0], shared, supply, wb}.
    function automatic logic [8:0] model(input logic [2:0] st, input logic r, w, e,
                                         input logic sv, input logic [1:0] sk,
                                         input logic shi);
        logic [2:0] n = st;
        logic bv = 0, sh = 0, sp = 0, wb = 0;
        logic [1:0] bk = 0;
        bit dirty = (st == 3'd3 || st == 3'd4);
        if (sv) begin
            if (sk == 2'd0) begin
                sh = (st != 3'd0);
                sp = dirty;
                if (st == 3'd4) n = 3'd3;
                if (st == 3'd2) n = 3'd1;
            end else if (sk == 2'd1) begin
                sp = dirty;
                n = 3'd0;
            end else n = 3'd0;
        end else if (e) begin
            wb = dirty;
            n = 3'd0;
        end else if (w) begin
            n = 3'd4;
            if (st == 3'd0) begin bv = 1; bk = 2'd1; end
            if (st == 3'd1 || st == 3'd3) begin bv = 1; bk = 2'd2; end
        end else if (r && st == 3'd0) begin
            bv = 1; bk = 2'd0;
            n = shi ? 3'd1 : 3'd2;
        end
        return {n, bv, bk, sh, sp, wb};
    endfunction

    function automatic string tag(input logic [2:0] st, input logic r, w, e,
                                  input logic sv, input logic [1:0] sk);
        if (sv && (r || w || e)) return "R9";
        if (sv) return (sk == 2'd0) ? ((st == 3'd4) ? "R4" : "R5") :
                       (sk == 2'd1) ? "R6" : "R7";
        if (e && (r || w)) return "R9";
        if (e) return "R8";
        if (w) return "R3";
        if (r) return "R2";
        return "R10";
    endfunction

    task automatic check(input string t, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs, then the state after the edge.
    task automatic step(input logic r, w, e, sv, input logic [1:0] sk, input logic shi);
        logic [8:0] ex;
        string t;
        @(negedge clk);
        loc_rd = r; loc_wr = w; evict = e; snp_valid = sv; snp_kind = sk; shared_in = shi;
        ex = model(exp_st, r, w, e, sv, sk, shi);
        t = tag(exp_st, r, w, e, sv, sk);
        #1;
        check(t, {state_q, bus_req_valid, bus_req_kind, shared_out, supply_out, wb_req},
              {exp_st, ex[5:0]});
        @(posedge clk);
        #1;
        exp_st = ex[8:6];
        check(t, {state_q, 6'b0}, {exp_st, 6'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1", {state_q, bus_req_valid, bus_req_kind, shared_out, supply_out, wb_req}, 9'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed: read alone -> E, snooped read -> S, write -> upgrade M
        step(1, 0, 0, 0, 0, 0);   // R2 I->E
        step(1, 0, 0, 0, 0, 0);   // R2 hit
        step(0, 0, 0, 1, 0, 0);   // R5 E->S
        step(0, 1, 0, 0, 0, 0);   // R3 S->M upgrade
        step(0, 0, 0, 1, 0, 0);   // R4 M->O supply
        step(0, 0, 0, 1, 0, 0);   // R5 O stays
        step(0, 1, 0, 0, 0, 0);   // R3 O->M upgrade
        step(0, 0, 0, 1, 2'd1, 0);// R6 M supplies, ->I
        step(1, 0, 0, 0, 0, 1);   // R2 I->S
        step(0, 0, 1, 0, 0, 0);   // R8 silent evict
        step(0, 1, 0, 0, 0, 0);   // R3 I->M RdX
        step(0, 0, 1, 0, 0, 0);   // R8 write-back
        step(0, 1, 1, 1, 2'd2, 0);// R9 snoop wins, I stays
        step(0, 0, 0, 0, 0, 0);   // R10 idle
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0);   // R9 evict beats write, wb
        step(0, 0, 0, 1, 2'd2, 0);// R7 upgrade in I
        for (int i = 0; i < 4000; i++) begin
            logic sv;
            sv = ($urandom % 4) == 0;
            step(($urandom % 5) < 2, ($urandom % 10) < 3, ($urandom % 10) == 0,
                 sv, 2'($urandom % 3), 1'($urandom % 2));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule